// File: doc/BRIEF.md
# Rotating Windowed Register File

This block holds a physical array of 32-bit registers. Only a 16-register logical window is visible at any time. Every logical index on the two read ports and the one write port is moved by a window base. The base counts in steps of four registers, and the index wraps around the end of the physical array. Because of this, a window placed near the top of the array continues from physical register 0.

The base changes in one of three ways:

- **Absolute set:** loads a new base value.
- **Relative rotate:** adds a signed 4-bit step to the base.
- **Restore:** reloads the base from a previously saved old-base value.

Every new base is reduced modulo the number of base positions, which is the physical count divided by four. The current base is always visible on an output. Reads are combinational. Writes and base changes take effect on the rising clock edge. Anything driven in the same cycle as a rotation still uses the base that was in force before that edge.

Top module: `win_regfile`

## Requirements
- R1: A synchronous active-low reset sets the base to 0 and clears every physical register to 0.
- R2: Both read ports and the write port address physical register (base*4 + logical) modulo NUM_PHYS, where NUM_PHYS defaults to 64. Read data follows the index combinationally.
- R3: A window that passes the top of the array continues from physical register 0. With base 15 and 64 registers, logical 4..15 map to physical 0..11 and logical 0..3 map to physical 60..63.
- R4: With rot_op = 2'b01, the base becomes abs_base modulo (NUM_PHYS/4) at the next rising edge.
- R5: With rot_op = 2'b10, rot_step is a 4-bit two's-complement step from -8 to +7. The base becomes (base + step) modulo (NUM_PHYS/4), and this wraps in both directions.
- R6: With rot_op = 2'b11, the base becomes saved_base modulo (NUM_PHYS/4) at the next rising edge.
- R7: With rot_op = 2'b00, the base holds, and abs_base, rot_step and saved_base have no effect.
- R8: A write or read in the same cycle as a rotation uses the base that was in force before the edge.
- R9: When wr_en is 0, no register changes. The two read ports return independent registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical write index |
| wr_data | input | 32 | Write data |
| rot_op | input | 2 | 00 hold, 01 absolute, 10 relative, 11 restore |
| abs_base | input | 8 | Absolute base value, reduced modulo |
| rot_step | input | 4 | Signed relative step |
| saved_base | input | 8 | Saved old-base value for restore |
| win_base | output | 4 | Current window base |

## Verification
Read data is due in the same cycle as its index, so the bench samples it shortly after changing the index, away from any edge. A write or a rotation is due one rising edge later. The bench drives both at a falling edge and samples the new base and contents at the following falling edge. For same-cycle cases, it reads before the edge to see the old base, then reads again after the edge.

// File: rtl/win_regfile_pkg.sv
// Shared types for the rotating windowed register file.
// Assumes nothing beyond IEEE 1800-2017.
package win_regfile_pkg;

    // Rotation command encoding seen on the rot_op port.
    typedef enum logic [1:0] {
        ROT_HOLD    = 2'b00,
        ROT_ABS     = 2'b01,
        ROT_REL     = 2'b10,
        ROT_RESTORE = 2'b11
    } rot_op_e;

    localparam int WIN_REGS = 16;
    localparam int LIDX_W   = 4;
    localparam int STEP_W   = 4;

endpackage

// File: rtl/win_base_ctrl.sv
// Window base register and its three update paths.
// Holds the base in units of four registers.
// Assumes NUM_POS is a power of two and VAL_W >= STEP_W and VAL_W >= BASE_W,
// so that two's-complement wrap of the sum equals the modulo reduction.
module win_base_ctrl
    import win_regfile_pkg::*;
#(
    parameter int NUM_POS = 16,
    parameter int VAL_W   = 8,
    localparam int BASE_W = $clog2(NUM_POS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rot_op_e             op,
    input  logic [VAL_W-1:0]    abs_val,
    input  logic [STEP_W-1:0]   step,
    input  logic [VAL_W-1:0]    saved_val,
    output logic [BASE_W-1:0]   base
);

    logic [VAL_W-1:0]  step_ext;
    logic [VAL_W-1:0]  rel_sum;
    logic [BASE_W-1:0] base_next;

    // Sign-extend the step and form the wide relative sum.
    always_comb begin
        step_ext = {{(VAL_W-STEP_W){step[STEP_W-1]}}, step};
        rel_sum  = VAL_W'(base) + step_ext;
    end

    // Pick the next base and reduce it modulo the position count.
    always_comb begin
        unique case (op)
            ROT_ABS:     base_next = BASE_W'(abs_val   % VAL_W'(NUM_POS));
            ROT_REL:     base_next = BASE_W'(rel_sum   % VAL_W'(NUM_POS));
            ROT_RESTORE: base_next = BASE_W'(saved_val % VAL_W'(NUM_POS));
            default:     base_next = base;
        endcase
    end

    // Base register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) base <= '0;
        else        base <= base_next;
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ROT_HOLD) |=> $stable(base));

    p_abs_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ROT_ABS && abs_val < VAL_W'(NUM_POS)) |=> (VAL_W'(base) == $past(abs_val)));

    p_restore_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ROT_RESTORE && saved_val < VAL_W'(NUM_POS)) |=> (VAL_W'(base) == $past(saved_val)));

    p_rel_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ROT_REL && step == '0) |=> $stable(base));

endmodule

// File: rtl/win_addr_map.sv
// Maps a logical window index to a physical register index.
// Assumes NUM_PHYS is a power of two, so the wrap is a truncation.
module win_addr_map
    import win_regfile_pkg::*;
#(
    parameter int NUM_PHYS = 64,
    localparam int PHYS_W  = $clog2(NUM_PHYS),
    localparam int BASE_W  = PHYS_W - 2
) (
    input  logic [BASE_W-1:0] base,
    input  logic [LIDX_W-1:0] lidx,
    output logic [PHYS_W-1:0] pidx
);

    logic [PHYS_W:0] sum;

    // Scale the base by four, add the logical index and wrap.
    always_comb begin
        sum  = {1'b0, base, 2'b00} + (PHYS_W+1)'(lidx);
        pidx = sum[PHYS_W-1:0];
    end

endmodule

// File: rtl/win_storage.sv
// Physical register array with NUM_RD combinational read ports and one write port.
// Assumes physical indices are already in range.
module win_storage #(
    parameter int NUM_PHYS = 64,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PHYS_W-1:0] raddr [NUM_RD],
    output logic [DATA_W-1:0] rdata [NUM_RD]
);

    logic [DATA_W-1:0] mem [NUM_PHYS];

    // Clear on reset, otherwise store the addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // Combinational read of one port.
        assign rdata[p] = mem[raddr[p]];
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/win_regfile.sv
// Top level: rotating 16-register window over a physical register array.
// Three address maps share the current base (two reads, one write).
// Assumes NUM_PHYS is a power of two of at least 16.
module win_regfile
    import win_regfile_pkg::*;
#(
    parameter int NUM_PHYS = 64,
    parameter int DATA_W   = 32,
    parameter int VAL_W    = 8,
    localparam int PHYS_W  = $clog2(NUM_PHYS),
    localparam int NUM_POS = NUM_PHYS / 4,
    localparam int BASE_W  = $clog2(NUM_POS),
    localparam int NUM_RD  = 2,
    localparam int NUM_MAP = NUM_RD + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rot_op,
    input  logic [VAL_W-1:0]  abs_base,
    input  logic [3:0]        rot_step,
    input  logic [VAL_W-1:0]  saved_base,
    output logic [BASE_W-1:0] win_base
);

    logic [BASE_W-1:0] base;
    logic [LIDX_W-1:0] lidx [NUM_MAP];
    logic [PHYS_W-1:0] pidx [NUM_MAP];
    logic [PHYS_W-1:0] raddr [NUM_RD];
    logic [DATA_W-1:0] rdata [NUM_RD];

    win_base_ctrl #(.NUM_POS(NUM_POS), .VAL_W(VAL_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (rot_op_e'(rot_op)),
        .abs_val   (abs_base),
        .step      (rot_step),
        .saved_val (saved_base),
        .base      (base)
    );

    // Gather the logical indices: read ports first, write port last.
    always_comb begin
        lidx[0] = rd_a_idx;
        lidx[1] = rd_b_idx;
        lidx[2] = wr_idx;
    end

    for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
        win_addr_map #(.NUM_PHYS(NUM_PHYS)) u_map (
            .base (base),
            .lidx (lidx[m]),
            .pidx (pidx[m])
        );
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_raddr
        // Route the mapped read addresses to storage.
        assign raddr[r] = pidx[r];
    end

    win_storage #(.NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (pidx[NUM_RD]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    // Drive the outputs.
    always_comb begin
        rd_a_data = rdata[0];
        rd_b_data = rdata[1];
        win_base  = base;
    end

    p_same_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

endmodule

// File: tb/win_regfile_test.sv
`timescale 1ns/1ps
module win_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, rot_step = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  rot_op = 2'b00;
    logic [7:0]  abs_base = '0, saved_base = '0;
    logic [3:0]  win_base;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    win_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rot_op(rot_op), .abs_base(abs_base), .rot_step(rot_step),
        .saved_base(saved_base), .win_base(win_base)
    );

    // {op[2], abs[8], step[4], saved[8], expected base[4]}, applied in order from base 0
    localparam logic [25:0] VEC [12] = '{
        {2'd1, 8'h05, 4'h0, 8'h00, 4'd5},   // R4
        {2'd2, 8'h00, 4'h7, 8'h00, 4'd12},  // R5 +7
        {2'd2, 8'h00, 4'h8, 8'h00, 4'd4},   // R5 -8
        {2'd2, 8'h00, 4'hF, 8'h00, 4'd3},   // R5 -1
        {2'd1, 8'h1E, 4'h0, 8'h00, 4'd14},  // R4 modulo
        {2'd3, 8'h00, 4'h0, 8'h47, 4'd7},   // R6 modulo
        {2'd0, 8'h33, 4'h5, 8'h2A, 4'd7},   // R7 hold
        {2'd2, 8'h00, 4'h7, 8'h00, 4'd14},  // R5
        {2'd2, 8'h00, 4'h3, 8'h00, 4'd1},   // R5 wrap up
        {2'd2, 8'h00, 4'hD, 8'h00, 4'd14},  // R5 wrap down
        {2'd3, 8'h00, 4'h0, 8'h09, 4'd9},   // R6
        {2'd1, 8'hF0, 4'h0, 8'h00, 4'd0}    // R4 modulo
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock step: drive at a falling edge, return at the next falling edge idle.
    task automatic step(input logic [1:0] op, input logic [7:0] ab, input logic [3:0] st,
                        input logic [7:0] sv, input logic we, input logic [3:0] wi,
                        input logic [31:0] wd);
        rot_op = op; abs_base = ab; rot_step = st; saved_base = sv;
        wr_en = we; wr_idx = wi; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        rot_op = 2'b00; wr_en = 1'b0;
    endtask

    task automatic read_a(input logic [3:0] idx, input string req, input logic [31:0] exp);
        rd_a_idx = idx;
        #0.5;
        check(req, rd_a_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset base", 32'(win_base), 32'd0);

        // Table walk of base updates
        for (int i = 0; i < 12; i++) begin
            step(VEC[i][25:24], VEC[i][23:16], VEC[i][15:12], VEC[i][11:4], 1'b0, 4'd0, 32'd0);
            check("R4/R5/R6/R7 base table", 32'(win_base), 32'(VEC[i][3:0]));
        end

        // R2: fill window at base 0, read back both ports
        for (int i = 0; i < 16; i++)
            step(2'b00, 8'h0, 4'h0, 8'h0, 1'b1, 4'(i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
            #0.5;
            check("R9 port A", rd_a_data, 32'hA000_0000 + 32'(i));
            check("R9 port B", rd_b_data, 32'hA000_0000 + 32'(15 - i));
        end

        // R2: rotate +1, window now physical 4..19
        step(2'b10, 8'h0, 4'h1, 8'h0, 1'b0, 4'd0, 32'd0);
        read_a(4'd0,  "R2 offset", 32'hA000_0004);
        read_a(4'd11, "R2 offset", 32'hA000_000F);
        read_a(4'd12, "R2 offset", 32'h0);

        // R8: rotate and write together; before the edge reads see the old base
        rot_op = 2'b10; rot_step = 4'h1; wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'hB000_0000;
        rd_a_idx = 4'd3;
        #0.5;
        check("R8 read old base", rd_a_data, 32'hA000_0007);
        @(posedge clk); @(negedge clk);
        rot_op = 2'b00; wr_en = 1'b0;
        check("R8 base moved", 32'(win_base), 32'd2);
        read_a(4'd0, "R8 new base unchanged", 32'hA000_0008);
        step(2'b10, 8'h0, 4'hF, 8'h0, 1'b0, 4'd0, 32'd0);
        read_a(4'd0, "R8 write used old base", 32'hB000_0000);

        // R3: wrap at base 15
        step(2'b01, 8'h0F, 4'h0, 8'h0, 1'b0, 4'd0, 32'd0);
        read_a(4'd4, "R3 wrap to phys 0", 32'hA000_0000);
        read_a(4'd3, "R3 phys 63", 32'h0);
        step(2'b00, 8'h0, 4'h0, 8'h0, 1'b1, 4'd15, 32'hC000_000F);
        step(2'b01, 8'h00, 4'h0, 8'h0, 1'b0, 4'd0, 32'd0);
        read_a(4'd11, "R3 wrapped write", 32'hC000_000F);

        // R9: disabled write changes nothing
        step(2'b00, 8'h0, 4'h0, 8'h0, 1'b0, 4'd2, 32'h0000_DEAD);
        read_a(4'd2, "R9 no write", 32'hA000_0002);

        // R1: reset clears contents and base
        step(2'b01, 8'h05, 4'h0, 8'h0, 1'b0, 4'd0, 32'd0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1 base after reset", 32'(win_base), 32'd0);
        for (int i = 0; i < 16; i++) read_a(4'(i), "R1 cleared", 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule